// File: doc/BRIEF.md
# Serial Pair Detector with Run Lockout

This block watches a serial stream of single bits, one bit per clock edge on which the valid strobe is high. It raises `detect` when the two most recent accepted bits are a one and then a zero, with the zero arriving last. It also counts runs of consecutive ones. When the run reaches `RUN_LIMIT` (three by default), the block enters a lockout state. In lockout `detect` is held low and `locked` is high until the next reset.

The machine is a Moore machine. The state sits in flip-flops, and a combinational stage computes the next state from the current state, the valid strobe and the bit. Both outputs are flip-flops loaded on the same edge as the state, so they change only at an edge that accepts a bit. A parameter chooses between a binary and a one-hot encoding for the state kind. An asynchronous active-low reset clears the history, the run count and the lockout.

Top module: `seqdet_lockout`

## Requirements
- R1: While `rst_n` is low, `detect` and `locked` are 0, and they fall as soon as reset is asserted, without waiting for a clock edge.
- R2: On a rising edge where `bit_valid` is 0, no bit is accepted and `detect` and `locked` keep their values, whatever `bit_in` is.
- R3: After an accepted 1 followed directly by an accepted 0, `detect` is 1 from the edge that accepted the 0, provided the block is not locked.
- R4: `detect` returns to 0 at the edge that accepts the next bit after the 1-then-0 pair, whether that bit is 0 or 1.
- R5: A 0 accepted with no 1 directly before it, including the first bit after reset, leaves `detect` at 0.
- R6: When `RUN_LIMIT` consecutive 1 bits have been accepted, `locked` becomes 1 and `detect` becomes 0 at the edge that accepts the last 1 of the run. This also applies to a run that starts with the first bit after reset.
- R7: Once `locked` is 1, it stays 1 and `detect` stays 0 for every later input, until reset.
- R8: An accepted 0 restarts the run count. With the default limit, the sequence 1,1,0,1,1 does not lock.
- R9: An asynchronous reset applied while the block is locked clears `locked`. After release, detection resumes from a state with no history.
- R10: Over any mix of valid and idle cycles, the outputs match the rules above one edge after each accepted bit. Both the binary and the one-hot state encoding give the same output sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; bits are accepted on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | High when `bit_in` carries a bit to accept |
| bit_in | input | 1 | Serial data bit |
| detect | output | 1 | High when the last two accepted bits were 1 then 0 and the block is not locked |
| locked | output | 1 | High once a run of `RUN_LIMIT` ones has been seen |

## Verification
The bench targets the cases where a detector like this usually goes wrong. A lone 0 after reset would raise `detect` in a design that treats "no history" as a previous 1. A run of two ones broken by a zero would lock a design that does not clear its run count on a zero. A run of three ones at the very start would be missed by a design that needs a leading zero before it counts. Idle cycles with a toggling `bit_in` would shift phantom bits into a design that ignores the valid strobe. The bench also checks that, once locked, the block stays locked through random traffic and is freed only by an asynchronous reset. Reference values come from a bit-level model in the bench, compared under random traffic with a fixed seed.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;
   typedef enum logic [1:0] {
      ST_ZERO = 2'd0,   // no history, or last accepted bit was 0 (not after a 1)
      ST_ONES = 2'd1,   // inside a run of ones; run length held separately
      ST_TEN  = 2'd2,   // last two accepted bits were 1 then 0
      ST_LOCK = 2'd3    // run limit reached; absorbs every input
   } kind_e;
   localparam int unsigned KIND_N = 4;
endpackage

// File: rtl/seqdet_next.sv
module seqdet_next
   import seqdet_pkg::*;
#(
   parameter int unsigned RUN_LIMIT = 3,
   parameter int unsigned RUN_W     = 2
) (
   input  kind_e            cur_kind,
   input  logic [RUN_W-1:0] cur_run,
   input  logic             bit_valid,
   input  logic             bit_in,
   output kind_e            nxt_kind,
   output logic [RUN_W-1:0] nxt_run
);
   localparam logic [RUN_W-1:0] LAST_BEFORE_LOCK = RUN_W'(RUN_LIMIT - 1);

   always_comb begin
      nxt_kind = cur_kind;
      nxt_run  = cur_run;
      if (bit_valid) begin
         case (cur_kind)
            ST_LOCK: begin
               nxt_kind = ST_LOCK;
               nxt_run  = '0;
            end
            ST_ONES: begin
               if (bit_in) begin
                  if (cur_run == LAST_BEFORE_LOCK) begin
                     nxt_kind = ST_LOCK;
                     nxt_run  = '0;
                  end else begin
                     nxt_run = cur_run + 1'b1;
                  end
               end else begin
                  nxt_kind = ST_TEN;
                  nxt_run  = '0;
               end
            end
            default: begin
               if (bit_in) begin
                  nxt_kind = ST_ONES;
                  nxt_run  = RUN_W'(1);
               end else begin
                  nxt_kind = ST_ZERO;
                  nxt_run  = '0;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/seqdet_state_reg.sv
module seqdet_state_reg
   import seqdet_pkg::*;
#(
   parameter int unsigned RUN_W        = 2,
   parameter bit          ONEHOT_STATE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  kind_e            nxt_kind,
   input  logic [RUN_W-1:0] nxt_run,
   output kind_e            cur_kind,
   output logic [RUN_W-1:0] cur_run
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_run <= '0;
      else        cur_run <= nxt_run;
   end

   generate
      if (ONEHOT_STATE) begin : g_onehot
         logic [KIND_N-1:0] kind_oh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) kind_oh <= KIND_N'(1) << ST_ZERO;
            else        kind_oh <= KIND_N'(1) << nxt_kind;
         end
         always_comb begin
            cur_kind = ST_ZERO;
            for (int i = 0; i < KIND_N; i++) begin
               if (kind_oh[i]) cur_kind = kind_e'(i);
            end
         end
      end else begin : g_binary
         kind_e kind_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) kind_q <= ST_ZERO;
            else        kind_q <= nxt_kind;
         end
         assign cur_kind = kind_q;
      end
   endgenerate
endmodule

// File: rtl/seqdet_out_reg.sv
module seqdet_out_reg
   import seqdet_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  kind_e nxt_kind,
   output logic  detect,
   output logic  locked
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         detect <= 1'b0;
         locked <= 1'b0;
      end else begin
         detect <= (nxt_kind == ST_TEN);
         locked <= (nxt_kind == ST_LOCK);
      end
   end
endmodule

// File: rtl/seqdet_lockout.sv
module seqdet_lockout
   import seqdet_pkg::*;
#(
   parameter int unsigned RUN_LIMIT    = 3,
   parameter bit          ONEHOT_STATE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_valid,
   input  logic bit_in,
   output logic detect,
   output logic locked
);
   localparam int unsigned RUN_W = $clog2(RUN_LIMIT + 1);

   generate
      if (RUN_LIMIT < 2) begin : g_bad_limit
         $error("seqdet_lockout: RUN_LIMIT must be at least 2");
      end
   endgenerate

   kind_e            cur_kind, nxt_kind;
   logic [RUN_W-1:0] cur_run, nxt_run;

   seqdet_next #(.RUN_LIMIT(RUN_LIMIT), .RUN_W(RUN_W)) u_next (
      .cur_kind (cur_kind),
      .cur_run  (cur_run),
      .bit_valid(bit_valid),
      .bit_in   (bit_in),
      .nxt_kind (nxt_kind),
      .nxt_run  (nxt_run)
   );

   seqdet_state_reg #(.RUN_W(RUN_W), .ONEHOT_STATE(ONEHOT_STATE)) u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .nxt_kind(nxt_kind),
      .nxt_run (nxt_run),
      .cur_kind(cur_kind),
      .cur_run (cur_run)
   );

   seqdet_out_reg u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .nxt_kind(nxt_kind),
      .detect  (detect),
      .locked  (locked)
   );
endmodule

// File: rtl/seqdet_lockout_chk.sv
module seqdet_lockout_chk (
   input logic clk,
   input logic rst_n,
   input logic bit_valid,
   input logic bit_in,
   input logic detect,
   input logic locked
);
   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> locked); // R7

   AST_LOCK_NO_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> !detect); // R6

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_valid |=> ($stable(detect) && $stable(locked))); // R2

   AST_DETECT_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(detect) |-> ($past(bit_valid) && !$past(bit_in))); // R3

   AST_LOCK_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> ($past(bit_valid) && $past(bit_in))); // R6
endmodule

bind seqdet_lockout seqdet_lockout_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bit_valid(bit_valid),
   .bit_in   (bit_in),
   .detect   (detect),
   .locked   (locked)
);

// File: tb/seqdet_lockout_tb.sv
module seqdet_lockout_tb;
   localparam int CLK_PERIOD = 10;
   localparam int LIMIT      = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_valid = 1'b0;
   logic bit_in = 1'b0;
   logic det_b, lck_b, det_o, lck_o;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   // bench reference model state
   bit m_lock;
   int m_run;
   bit m_last_v, m_last, m_prev_v, m_prev;

   always #(CLK_PERIOD/2) clk = ~clk;

   seqdet_lockout #(.RUN_LIMIT(LIMIT), .ONEHOT_STATE(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
      .detect(det_b), .locked(lck_b));

   seqdet_lockout #(.RUN_LIMIT(LIMIT), .ONEHOT_STATE(1'b1)) u_dut_oh (
      .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
      .detect(det_o), .locked(lck_o));

   function automatic void mdl_reset();
      m_lock = 0; m_run = 0;
      m_last_v = 0; m_last = 0; m_prev_v = 0; m_prev = 0;
   endfunction

   function automatic void mdl_step(input bit b);
      if (m_lock) return;
      if (b) begin
         m_run++;
         if (m_run >= LIMIT) m_lock = 1;
      end else begin
         m_run = 0;
      end
      m_prev_v = m_last_v; m_prev = m_last;
      m_last_v = 1;        m_last = b;
   endfunction

   function automatic bit exp_det();
      return !m_lock && m_last_v && !m_last && m_prev_v && m_prev;
   endfunction

   task automatic check(input string req);
      bit ed, el;
      ed = exp_det();
      el = m_lock;
      n_checks++;
      if (det_b !== ed || lck_b !== el || det_o !== ed || lck_o !== el) begin
         n_errors++;
         $display("FAIL %s: detect=%b/%b locked=%b/%b (binary/onehot), expected detect=%b locked=%b",
                  req, det_b, det_o, lck_b, lck_o, ed, el);
      end
   endtask

   // drive one cycle: inputs set 1 unit after the edge, checked 1 unit after next edge
   task automatic apply(input bit v, input bit b, input string req);
      bit_valid = v;
      bit_in    = b;
      @(posedge clk);
      if (v) mdl_step(b);
      #1;
      check(req);
   endtask

   task automatic do_reset(input string req);
      rst_n = 1'b0;
      #1;
      mdl_reset();
      check(req);
      @(posedge clk);
      #1;
      rst_n = 1'b1;
   endtask

   initial begin
      int unsigned seed_dummy;
      mdl_reset();
      seed_dummy = $urandom(32'h5EED_0042);
      @(posedge clk); @(posedge clk);
      #1;
      check("R1");
      rst_n = 1'b1;

      apply(1, 0, "R5");                  // lone 0 after reset
      apply(1, 1, "R3");
      apply(1, 0, "R3");                  // detect up
      apply(1, 0, "R4");                  // falls on next 0
      apply(1, 1, "R3");
      apply(1, 0, "R3");
      apply(1, 1, "R4");                  // falls on next 1
      apply(1, 0, "R3");
      for (int i = 0; i < 3; i++) apply(0, i[0], "R2"); // idle, detect held high
      apply(1, 0, "R4");
      for (int i = 0; i < 3; i++) apply(0, 1'b1, "R2"); // idle ones do not count
      apply(1, 1, "R8");
      apply(1, 1, "R8");
      apply(1, 0, "R8");                  // run broken, detect up
      apply(1, 1, "R8");
      apply(1, 1, "R8");                  // 1,1,0,1,1 not locked
      apply(0, 1, "R2");
      apply(1, 1, "R6");                  // third consecutive one locks
      for (int i = 0; i < 12; i++) apply(1, i[0], "R7");
      apply(0, 0, "R7");

      do_reset("R9");                     // asynchronous clear while locked
      apply(1, 1, "R6");
      apply(1, 1, "R6");
      apply(1, 1, "R6");                  // run from reset locks
      do_reset("R1");
      apply(1, 1, "R9");
      apply(1, 0, "R9");                  // detection resumes after reset

      for (int i = 0; i < 3000; i++) begin
         bit v, b;
         v = ($urandom_range(0, 3) != 0);
         b = ($urandom_range(0, 9) < 4);
         apply(v, b, "R10");
         if ($urandom_range(0, 199) == 0) do_reset("R9");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule